// File: doc/BRIEF.md
# D-PHY Test-Port Register Write Engine

This block writes one byte into one internal 8-bit register of a MIPI D-PHY through the PHY's serial test port. A requester gives an 8-bit register address (the test code) and an 8-bit value through a valid/ready handshake. The engine then moves the test clock, test enable, test clear, the 8-bit test data bus and an 8-bit marker field through a fixed six-step choreography. The address is latched by the PHY on a falling test-clock edge while enable is high. The value is latched on a rising test-clock edge while enable is low.

Every step lasts `HOLD_CYCLES` system clocks, so that the PHY's setup and hold times are met at any system clock rate. A one-cycle `done` pulse marks the end of each write. A request offered while a write is in progress waits: it is neither dropped nor merged.

Top module: `phy_test_writer`

## Requirements
- R1: After reset, and whenever no write is in progress, `req_ready` is 1, `done` is 0, and `phy_testclk`, `phy_testen`, `phy_testdin` and `phy_marker` are all 0.
- R2: `phy_testclr` is 0 in every cycle, during writes and while idle.
- R3: Step 1 of a write drives `phy_testclk`=1 and `phy_testen`=0, with `phy_testdin`=0x00 and `phy_marker`=0x00.
- R4: Step 2 keeps `phy_testclk`=1, sets `phy_testen`=1, places the accepted code on `phy_testdin` and sets `phy_marker`=0x01.
- R5: Step 3 drops `phy_testclk` to 0 and keeps `phy_testen`=1, the code on `phy_testdin` and `phy_marker`=0x01, so the code is latched on a falling edge.
- R6: Step 4 keeps `phy_testclk`=0, sets `phy_testen`=0, places the accepted data on `phy_testdin` and sets `phy_marker`=0x00.
- R7: Step 5 raises `phy_testclk` to 1 with `phy_testen`=0 and the data still on `phy_testdin`, so the data is latched on a rising edge.
- R8: Step 6 drops `phy_testclk` to 0 with `phy_testen`=0 and the data still on `phy_testdin`, which ends the write.
- R9: Each of the six steps lasts exactly `HOLD_CYCLES` system clock cycles (`HOLD_CYCLES` >= 1). Step 1 begins in the cycle after the accepting edge.
- R10: `req_ready` is 0 from the accepting edge until the write ends. `done` is 1 for exactly one cycle, the (6*`HOLD_CYCLES`+1)-th cycle after the accepting edge. In that cycle `req_ready` is already 1 and the pins are back at rest.
- R11: A request held valid while a write is in progress is not accepted and does not alter the code or data of the write in progress. It is accepted on the first edge at which `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Engine can accept a request this cycle |
| req_code | input | 8 | PHY register address (test code) |
| req_data | input | 8 | Value to write into the register |
| done | output | 1 | One-cycle pulse when a write has finished |
| phy_testclk | output | 1 | PHY test-port clock |
| phy_testclr | output | 1 | PHY test-port clear, held low |
| phy_testen | output | 1 | PHY test-port enable: 1 = address phase |
| phy_testdin | output | 8 | PHY test-port data bus |
| phy_marker | output | 8 | Phase marker field: 0x01 in the address phase, else 0x00 |

## Verification
A request is taken on the rising edge at which `req_valid` and `req_ready` are both 1. Step k then occupies cycles (k-1)*`HOLD_CYCLES`+1 through k*`HOLD_CYCLES` after that edge, and `done` arrives in cycle 6*`HOLD_CYCLES`+1. The bench synchronises on the accepting edge. It then samples at every falling edge for the full 6*`HOLD_CYCLES` cycles and compares each sample with the value due in that cycle, which also pins the length of each step. The cycle after the `done` sample is checked separately to confirm that the pulse lasts a single cycle. In the stall scenario a different request is kept valid throughout the first write, and the bench checks both that it leaves the first write untouched and that it starts on the edge right after `done`.

// File: rtl/phy_tw_pkg.sv
package phy_tw_pkg;

   localparam int unsigned TW_BYTE_W = 8;
   localparam logic [TW_BYTE_W-1:0] TW_MARK_ADDR = 8'h01;

   typedef enum logic [2:0] {
      TW_IDLE       = 3'd0,
      TW_CLK_UP     = 3'd1,
      TW_ADDR       = 3'd2,
      TW_ADDR_LATCH = 3'd3,
      TW_VAL        = 3'd4,
      TW_VAL_LATCH  = 3'd5,
      TW_CLOSE      = 3'd6
   } tw_step_e;

   // Lane control word: enable at bit 16, marker at 15:8, data bus at 7:0.
   typedef struct packed {
      logic                 en;
      logic [TW_BYTE_W-1:0] mark;
      logic [TW_BYTE_W-1:0] din;
   } tw_lane_word_t;

   // Edge control word: test clock at bit 1, test clear at bit 0.
   typedef struct packed {
      logic clk;
      logic clr;
   } tw_edge_word_t;

   function automatic tw_step_e tw_next(input tw_step_e s);
      case (s)
         TW_CLK_UP:     return TW_ADDR;
         TW_ADDR:       return TW_ADDR_LATCH;
         TW_ADDR_LATCH: return TW_VAL;
         TW_VAL:        return TW_VAL_LATCH;
         TW_VAL_LATCH:  return TW_CLOSE;
         default:       return TW_IDLE;
      endcase
   endfunction

endpackage

// File: rtl/phy_tw_step_timer.sv
module phy_tw_step_timer #(
   parameter int unsigned HOLD_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic step_end
);

   generate
      if (HOLD_CYCLES == 1) begin : g_single
         logic unused_tick;
         assign unused_tick = clk ^ rst_n;
         assign step_end    = run;
      end else begin : g_count
         localparam int unsigned CNT_W = $clog2(HOLD_CYCLES);
         localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYCLES - 1);
         logic [CNT_W-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt <= '0;
            end else if (!run || cnt == LAST) begin
               cnt <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end

         assign step_end = run && (cnt == LAST);
      end
   endgenerate

endmodule

// File: rtl/phy_tw_sequencer.sv
module phy_tw_sequencer
   import phy_tw_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   input  logic [TW_BYTE_W-1:0] req_code,
   input  logic [TW_BYTE_W-1:0] req_data,
   input  logic                 step_end,
   output tw_step_e             step,
   output logic [TW_BYTE_W-1:0] code_q,
   output logic [TW_BYTE_W-1:0] data_q,
   output logic                 ready,
   output logic                 done
);

   logic accept;

   assign ready  = (step == TW_IDLE);
   assign accept = req_valid && ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step   <= TW_IDLE;
         code_q <= '0;
         data_q <= '0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (accept) begin
            step   <= TW_CLK_UP;
            code_q <= req_code;
            data_q <= req_data;
         end else if (step_end) begin
            if (step == TW_CLOSE) begin
               step <= TW_IDLE;
               done <= 1'b1;
            end else begin
               step <= tw_next(step);
            end
         end
      end
   end

endmodule

// File: rtl/phy_tw_pin_driver.sv
module phy_tw_pin_driver
   import phy_tw_pkg::*;
(
   input  tw_step_e             step,
   input  logic [TW_BYTE_W-1:0] code_q,
   input  logic [TW_BYTE_W-1:0] data_q,
   output tw_edge_word_t        edge_w,
   output tw_lane_word_t        lane_w
);

   always_comb begin
      edge_w = '0;
      lane_w = '0;
      case (step)
         TW_CLK_UP: begin
            edge_w.clk = 1'b1;
         end
         TW_ADDR: begin
            edge_w.clk  = 1'b1;
            lane_w.en   = 1'b1;
            lane_w.mark = TW_MARK_ADDR;
            lane_w.din  = code_q;
         end
         TW_ADDR_LATCH: begin
            lane_w.en   = 1'b1;
            lane_w.mark = TW_MARK_ADDR;
            lane_w.din  = code_q;
         end
         TW_VAL: begin
            lane_w.din = data_q;
         end
         TW_VAL_LATCH: begin
            edge_w.clk = 1'b1;
            lane_w.din = data_q;
         end
         TW_CLOSE: begin
            lane_w.din = data_q;
         end
         default: begin
            edge_w = '0;
            lane_w = '0;
         end
      endcase
   end

endmodule

// File: rtl/phy_test_writer.sv
module phy_test_writer
   import phy_tw_pkg::*;
#(
   parameter int unsigned HOLD_CYCLES = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_valid,
   output logic       req_ready,
   input  logic [7:0] req_code,
   input  logic [7:0] req_data,
   output logic       done,
   output logic       phy_testclk,
   output logic       phy_testclr,
   output logic       phy_testen,
   output logic [7:0] phy_testdin,
   output logic [7:0] phy_marker
);

   generate
      if (HOLD_CYCLES < 1) begin : g_bad_hold
         $error("phy_test_writer: HOLD_CYCLES must be at least 1");
      end
   endgenerate

   tw_step_e             step;
   logic                 step_end;
   logic [TW_BYTE_W-1:0] code_q;
   logic [TW_BYTE_W-1:0] data_q;
   tw_edge_word_t        edge_w;
   tw_lane_word_t        lane_w;

   phy_tw_step_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (step != TW_IDLE),
      .step_end (step_end)
   );

   phy_tw_sequencer u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_code  (req_code),
      .req_data  (req_data),
      .step_end  (step_end),
      .step      (step),
      .code_q    (code_q),
      .data_q    (data_q),
      .ready     (req_ready),
      .done      (done)
   );

   phy_tw_pin_driver u_pins (
      .step   (step),
      .code_q (code_q),
      .data_q (data_q),
      .edge_w (edge_w),
      .lane_w (lane_w)
   );

   assign phy_testclk = edge_w.clk;
   assign phy_testclr = edge_w.clr;
   assign phy_testen  = lane_w.en;
   assign phy_testdin = lane_w.din;
   assign phy_marker  = lane_w.mark;

endmodule

// File: rtl/phy_tw_checker.sv
module phy_tw_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       req_valid,
   input logic       req_ready,
   input logic       done,
   input logic       phy_testclk,
   input logic       phy_testclr,
   input logic       phy_testen,
   input logic [7:0] phy_testdin,
   input logic [7:0] phy_marker
);

   a_r2_clear_low: assert property (@(posedge clk) disable iff (!rst_n)
      phy_testclr == 1'b0);

   a_r1_rest_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (!phy_testclk && !phy_testen &&
                     phy_testdin == 8'h00 && phy_marker == 8'h00));

   a_r4_en_rises_clk_high: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(phy_testen) |-> phy_testclk);

   a_r6_en_falls_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(phy_testen) |-> !phy_testclk);

   a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r10_done_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> req_ready);

   a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(req_ready) |-> $past(req_valid));

   a_r11_bus_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_ready && $stable(phy_testen)) |-> $stable(phy_testdin));

endmodule

bind phy_test_writer phy_tw_checker u_tw_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_ready   (req_ready),
   .done        (done),
   .phy_testclk (phy_testclk),
   .phy_testclr (phy_testclr),
   .phy_testen  (phy_testen),
   .phy_testdin (phy_testdin),
   .phy_marker  (phy_marker)
);

// File: tb/tb_phy_test_writer.sv
`timescale 1ns/1ps
module tb_phy_test_writer;

   localparam int unsigned HOLD = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [7:0] req_code = 8'h00;
   logic [7:0] req_data = 8'h00;
   logic       req_ready, done;
   logic       phy_testclk, phy_testclr, phy_testen;
   logic [7:0] phy_testdin, phy_marker;

   int checks = 0;
   int errors = 0;
   int cyc    = 0;
   bit ended  = 1'b0;

   always #2 clk = ~clk;

   phy_test_writer #(.HOLD_CYCLES(HOLD)) dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_ready   (req_ready),
      .req_code    (req_code),
      .req_data    (req_data),
      .done        (done),
      .phy_testclk (phy_testclk),
      .phy_testclr (phy_testclr),
      .phy_testen  (phy_testen),
      .phy_testdin (phy_testdin),
      .phy_marker  (phy_marker)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 20000 && !ended) begin
         ended = 1'b1;
         errors++;
         $display("FAIL watchdog: run hung, got cycle=%0d expected <=20000", cyc);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   // Compare all outputs with the expected values; R2 (clear low) on every sample.
   task automatic check_pins(input string req, input logic eclk, input logic een,
                             input logic [7:0] edin, input logic [7:0] emark,
                             input logic erdy, input logic edone);
      checks++;
      if (phy_testclk !== eclk || phy_testen !== een || phy_testdin !== edin ||
          phy_marker !== emark || req_ready !== erdy || done !== edone) begin
         errors++;
         $display("FAIL %s: got clk=%b en=%b din=%h mark=%h rdy=%b done=%b expected clk=%b en=%b din=%h mark=%h rdy=%b done=%b",
                  req, phy_testclk, phy_testen, phy_testdin, phy_marker, req_ready, done,
                  eclk, een, edin, emark, erdy, edone);
      end
      checks++;
      if (phy_testclr !== 1'b0) begin
         errors++;
         $display("FAIL R2: got testclr=%b expected 0", phy_testclr);
      end
   endtask

   function automatic string step_tag(input int s);
      case (s)
         1: return "R3";
         2: return "R4";
         3: return "R5";
         4: return "R6";
         5: return "R7";
         default: return "R8";
      endcase
   endfunction

   // {clk, en, din, mark} expected in step s
   function automatic logic [17:0] exp_step(input int s, input logic [7:0] c,
                                            input logic [7:0] d);
      case (s)
         1: return {1'b1, 1'b0, 8'h00, 8'h00};
         2: return {1'b1, 1'b1, c,     8'h01};
         3: return {1'b0, 1'b1, c,     8'h01};
         4: return {1'b0, 1'b0, d,     8'h00};
         5: return {1'b1, 1'b0, d,     8'h00};
         default: return {1'b0, 1'b0, d, 8'h00};
      endcase
   endfunction

   task automatic offer(input logic [7:0] c, input logic [7:0] d);
      @(negedge clk);
      req_valid = 1'b1;
      req_code  = c;
      req_data  = d;
      while (!req_ready) @(negedge clk);
      @(posedge clk);
      #1;
   endtask

   // Called just after the accepting edge; R9: each step sampled in all HOLD cycles.
   task automatic walk(input logic [7:0] c, input logic [7:0] d, input bit keep,
                       input logic [7:0] nc, input logic [7:0] nd);
      logic [17:0] e;
      if (keep) begin
         req_code = nc;
         req_data = nd;
      end else begin
         req_valid = 1'b0;
      end
      for (int s = 1; s <= 6; s++) begin
         for (int h = 0; h < int'(HOLD); h++) begin
            @(negedge clk);
            e = exp_step(s, c, d);
            check_pins(keep ? {step_tag(s), "/R9/R11"} : {step_tag(s), "/R9"},
                       e[17], e[16], e[15:8], e[7:0], 1'b0, 1'b0);
         end
      end
      @(negedge clk);
      check_pins("R10", 1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 1'b1);
   endtask

   task automatic t_reset;
      #1;
      check_pins("R1", 1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0);
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      check_pins("R1", 1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0);
   endtask

   task automatic t_single(input logic [7:0] c, input logic [7:0] d);
      offer(c, d);
      walk(c, d, 1'b0, 8'h00, 8'h00);
      @(negedge clk);
      check_pins("R10/R1", 1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0);
   endtask

   task automatic t_stall(input logic [7:0] ca, input logic [7:0] da,
                          input logic [7:0] cb, input logic [7:0] db);
      offer(ca, da);
      walk(ca, da, 1'b1, cb, db);
      @(posedge clk);
      #1;
      walk(cb, db, 1'b0, 8'h00, 8'h00);
      @(negedge clk);
      check_pins("R11/R10", 1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0);
   endtask

   initial begin
      t_reset();
      t_single(8'h10, 8'h3C);
      t_single(8'hFF, 8'h00);
      t_single(8'h00, 8'hFF);
      t_stall(8'h17, 8'h5A, 8'h18, 8'hA5);
      repeat (4) @(negedge clk);
      check_pins("R1", 1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0);
      if (!ended) begin
         ended = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule